// File: doc/BRIEF.md
# Time-State Instruction Controller

This block sequences a small accumulator machine through one chain of eight timing states, T0 to T7. Every instruction walks the same chain. The two-bit opcode and the accumulator sign bit decide which register-transfer strobe fires in each step and where the instruction ends. The block has no separate state path per instruction. The datapath, the memory and the ALU sit outside it. The block reads only the opcode bits of the instruction register, the sign bit of the accumulator and a memory wait input.

Steps T0 to T3 fetch and decode the instruction and are the same for every opcode. Steps T4 to T7 execute it.

- Load and add share the full chain. They differ only in the strobe issued at T7.
- Store finishes at T5, after its memory write.
- A branch on a negative accumulator loads the program counter at T4.
- A branch on a non-negative accumulator finishes at T3.

The last step of each instruction raises a one-cycle done pulse, and the state returns to T0. While the wait input is high the current state is held, and the block suppresses every strobe except a pending memory read or write.

Top module: `time_state_ctrl`

States: T0 fetch address, T1 instruction read, T2 instruction capture, T3 decode and PC increment, T4 operand address or branch, T5 operand read or store write, T6 data capture, T7 accumulator update.

Transitions, taken only when wait is low:
- T0→T1, T1→T2, T2→T3.
- T3→T0 for a branch whose condition is not met, otherwise T3→T4.
- T4→T0 for a branch, otherwise T4→T5.
- T5→T0 for store, otherwise T5→T6.
- T6→T7, T7→T0.

## Requirements
- R1: Synchronous active-high reset places the controller in T0 on the next clock edge. After reset, tstate is 8'b0000_0001 and done is low, and no strobe is issued while wait is high.
- R2: Exactly one bit of tstate is high in every cycle, and bit i means state Ti.
- R3: While mem_wait is high the state does not change and done is low. The only strobe that may be asserted in such a cycle is the memory read (ctl bit 1) or memory write (ctl bit 6) belonging to the current step.
- R4: For every opcode, the fetch steps issue these strobes in order: T0 PC-to-address (ctl bit 0), T1 memory read (bit 1), T2 instruction capture (bit 2) and T3 PC increment (bit 3).
- R5: Load (ir_op 00) then issues operand address (bit 4) at T4, memory read (bit 1) at T5, data capture (bit 7) at T6 and accumulator load (bit 8) at T7, with done at T7.
- R6: Store (ir_op 01) issues operand address (bit 4) at T4 and memory write (bit 6) at T5, with done at T5, and then returns to T0.
- R7: Add (ir_op 10) follows the load sequence, except that T7 issues accumulator add (bit 9) instead of accumulator load.
- R8: A branch (ir_op 11) with ac_sign 0 raises done at T3 and next enters T0, skipping T4 to T7.
- R9: A branch with ac_sign 1 continues to T4, where it issues PC load (bit 5) with done, and then returns to T0.
- R10: At most one bit of ctl is high in any cycle.
- R11: done is high for exactly the advancing cycle of an instruction's last step, and the next state is T0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_wait | input | 1 | Memory not ready; holds the current time state |
| ir_op | input | 2 | Instruction register bits 15:14 (opcode) |
| ac_sign | input | 1 | Accumulator bit 15 (sign) |
| tstate | output | 8 | One-hot current time state, bit i = Ti |
| ctl | output | 10 | Register-transfer strobes, at most one high |
| done | output | 1 | One-cycle pulse in the last step of an instruction |

## Verification
The bench builds the block with the package defaults: eight time states, a two-bit opcode and ten strobe lines. With these values every opcode and every sign value is covered, and so every state and every transition listed above can be reached. A per-step wait mask stretches any chosen step by two cycles. This exercises holds at the memory steps, at the decode step of a branch that is not taken and at the branch step. The bench also applies a reset in the middle of a load.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int NUM_TS  = 8;
    localparam int TSW     = $clog2(NUM_TS);
    localparam int OPW     = 2;
    localparam int NUM_CTL = 10;

    typedef enum logic [TSW-1:0] {
        T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
        T4 = 3'd4, T5 = 3'd5, T6 = 3'd6, T7 = 3'd7
    } tstate_e;

    typedef enum logic [OPW-1:0] {
        OP_LD  = 2'd0,
        OP_ST  = 2'd1,
        OP_ADD = 2'd2,
        OP_BRN = 2'd3
    } op_e;

    // strobe bit positions on the ctl bus
    localparam int CTL_MAR_PC = 0;
    localparam int CTL_MEM_RD = 1;
    localparam int CTL_IR_LD  = 2;
    localparam int CTL_PC_INC = 3;
    localparam int CTL_MAR_IR = 4;
    localparam int CTL_PC_LD  = 5;
    localparam int CTL_MEM_WR = 6;
    localparam int CTL_MDR_LD = 7;
    localparam int CTL_AC_LD  = 8;
    localparam int CTL_AC_ADD = 9;
endpackage

// File: rtl/tsc_sequencer.sv
module tsc_sequencer
    import tsc_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic [OPW-1:0] op,
    input  logic           sign,
    output tstate_e        state
);
    tstate_e nxt;
    op_e     opc;

    assign opc = op_e'(op);

    always_comb begin
        nxt = state;
        if (!hold) begin
            unique case (state)
                T0: nxt = T1;
                T1: nxt = T2;
                T2: nxt = T3;
                T3: nxt = (opc == OP_BRN && !sign) ? T0 : T4;
                T4: nxt = (opc == OP_BRN) ? T0 : T5;
                T5: nxt = (opc == OP_ST) ? T0 : T6;
                T6: nxt = T7;
                T7: nxt = T0;
                default: nxt = T0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= T0;
        else     state <= nxt;
    end

    // R3: a wait cycle freezes the time state
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(state));
endmodule

// File: rtl/tsc_strobe_dec.sv
module tsc_strobe_dec
    import tsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  tstate_e            state,
    input  logic               hold,
    input  logic [OPW-1:0]     op,
    input  logic               sign,
    output logic [NUM_TS-1:0]  ts_onehot,
    output logic [NUM_CTL-1:0] ctl,
    output logic               done
);
    op_e  opc;
    logic adv;

    assign opc = op_e'(op);
    assign adv = !hold;

    for (genvar g = 0; g < NUM_TS; g++) begin : g_ts
        assign ts_onehot[g] = (state == tstate_e'(g));
    end

    always_comb begin
        ctl  = '0;
        done = 1'b0;
        unique case (state)
            T0: ctl[CTL_MAR_PC] = adv;
            T1: ctl[CTL_MEM_RD] = 1'b1;
            T2: ctl[CTL_IR_LD]  = adv;
            T3: begin
                ctl[CTL_PC_INC] = adv;
                done = adv && (opc == OP_BRN) && !sign;
            end
            T4: begin
                if (opc == OP_BRN) begin
                    ctl[CTL_PC_LD] = adv;
                    done = adv;
                end else begin
                    ctl[CTL_MAR_IR] = adv;
                end
            end
            T5: begin
                if (opc == OP_ST) begin
                    ctl[CTL_MEM_WR] = 1'b1;
                    done = adv;
                end else begin
                    ctl[CTL_MEM_RD] = 1'b1;
                end
            end
            T6: ctl[CTL_MDR_LD] = adv;
            T7: begin
                if (opc == OP_ADD) ctl[CTL_AC_ADD] = adv;
                else               ctl[CTL_AC_LD]  = adv;
                done = adv;
            end
            default: ;
        endcase
    end

    // R2: one time-state indicator per cycle
    assert_ts_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot(ts_onehot));
    // R10: never two strobes together
    assert_ctl_onehot0_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctl));
endmodule

// File: rtl/time_state_ctrl.sv
module time_state_ctrl
    import tsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mem_wait,
    input  logic [OPW-1:0]     ir_op,
    input  logic               ac_sign,
    output logic [NUM_TS-1:0]  tstate,
    output logic [NUM_CTL-1:0] ctl,
    output logic               done
);
    tstate_e state;

    tsc_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .hold  (mem_wait),
        .op    (ir_op),
        .sign  (ac_sign),
        .state (state)
    );

    tsc_strobe_dec u_dec (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .hold      (mem_wait),
        .op        (ir_op),
        .sign      (ac_sign),
        .ts_onehot (tstate),
        .ctl       (ctl),
        .done      (done)
    );

    // R1: reset lands in T0 with no done pulse
    assert_reset_t0_R1: assert property (@(posedge clk)
        rst |=> (tstate == 8'b0000_0001) && !done);
    // R11: the cycle after done is T0
    assert_done_to_t0_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> tstate[0]);
    // R3: no completion while waiting
    assert_no_done_wait_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wait |-> !done);
    // R8: branch not taken skips the execute states
    assert_skip_R8: assert property (@(posedge clk) disable iff (rst)
        (tstate[3] && !mem_wait && ir_op == 2'b11 && !ac_sign) |=> tstate[0]);
    // R9: branch taken goes on to T4
    assert_taken_R9: assert property (@(posedge clk) disable iff (rst)
        (tstate[3] && !mem_wait && ir_op == 2'b11 && ac_sign) |=> tstate[4]);
endmodule

// File: tb/sim_time_state_ctrl.sv
module sim_time_state_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mem_wait = 1'b1;
    logic [1:0] ir_op = 2'b00;
    logic       ac_sign = 1'b0;
    logic [7:0] tstate;
    logic [9:0] ctl;
    logic       done;

    time_state_ctrl u0 (
        .clk(clk), .rst(rst), .mem_wait(mem_wait), .ir_op(ir_op),
        .ac_sign(ac_sign), .tstate(tstate), .ctl(ctl), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] ts;
        logic [9:0] c;
        logic       d;
        int         req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: ts %b ctl %b done %b expected queued item",
                         tstate, ctl, done);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (tstate !== e.ts || ctl !== e.c || done !== e.d) begin
                    errors++;
                    $display("FAIL R%0d ts %b ctl %b done %b expected ts %b ctl %b done %b",
                             e.req, tstate, ctl, done, e.ts, e.c, e.d);
                end
            end
        end
    end

    // one step: optional wait cycles, then the advancing cycle
    task automatic step(input int s, input int b, input bit is_mem,
                        input bit last, input int nwait, input int req);
        for (int i = 0; i < nwait; i++) begin
            exp_t w;
            mem_wait = 1'b1;
            w.ts = 8'(1 << s); w.c = is_mem ? 10'(1 << b) : 10'd0;
            w.d = 1'b0; w.req = 3;  // R3 hold
            q.push_back(w);
            @(posedge clk); #1;
        end
        begin
            exp_t a;
            mem_wait = 1'b0;
            a.ts = 8'(1 << s); a.c = 10'(1 << b); a.d = last; a.req = req;
            q.push_back(a);
            @(posedge clk); #1;
        end
    endtask

    task automatic run(input logic [1:0] op, input logic sg, input logic [7:0] wm);
        ir_op = op; ac_sign = sg;
        // R4 fetch
        step(0, 0, 0, 0, wm[0] ? 2 : 0, 4);
        step(1, 1, 1, 0, wm[1] ? 2 : 0, 4);
        step(2, 2, 0, 0, wm[2] ? 2 : 0, 4);
        if (op == 2'b11 && !sg) begin
            step(3, 3, 0, 1, wm[3] ? 2 : 0, 8);          // R8 early exit
            return;
        end
        step(3, 3, 0, 0, wm[3] ? 2 : 0, 4);
        if (op == 2'b11) begin
            step(4, 5, 0, 1, wm[4] ? 2 : 0, 9);          // R9 taken
            return;
        end
        step(4, 4, 0, 0, wm[4] ? 2 : 0, 5);
        if (op == 2'b01) begin
            step(5, 6, 1, 1, wm[5] ? 2 : 0, 6);          // R6 store
            return;
        end
        step(5, 1, 1, 0, wm[5] ? 2 : 0, 5);
        step(6, 7, 0, 0, wm[6] ? 2 : 0, 5);
        if (op == 2'b10) step(7, 9, 0, 1, wm[7] ? 2 : 0, 7);  // R7 add
        else             step(7, 8, 0, 1, wm[7] ? 2 : 0, 5);  // R5 load, R11 done
    endtask

    task automatic chk_reset(input string tag);
        @(negedge clk);
        checks++;
        // R1: T0, no strobe with wait high, no done
        if (tstate !== 8'b0000_0001 || ctl !== 10'd0 || done !== 1'b0) begin
            errors++;
            $display("FAIL R1 %s ts %b ctl %b done %b expected ts 00000001 ctl 0 done 0",
                     tag, tstate, ctl, done);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: got hung run, expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; mem_wait = 1'b1;
        repeat (3) @(posedge clk);
        chk_reset("power-up");
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1'b1;
        run(2'b00, 1'b0, 8'h00);   // R5
        run(2'b01, 1'b1, 8'h00);   // R6
        run(2'b10, 1'b0, 8'h00);   // R7
        run(2'b11, 1'b0, 8'h00);   // R8
        run(2'b11, 1'b1, 8'h00);   // R9
        run(2'b00, 1'b1, 8'hFF);   // R3 on every step
        run(2'b01, 1'b0, 8'h22);   // R3 store write hold
        run(2'b11, 1'b0, 8'h08);   // R3 hold at branch exit
        run(2'b11, 1'b1, 8'h10);   // R3 hold at branch step
        run(2'b10, 1'b1, 8'hA0);   // R7 with holds
        run(2'b10, 1'b0, 8'h41);   // R10 back-to-back
        mon_on = 1'b0;
        // R1 reset in the middle of a load
        ir_op = 2'b00; mem_wait = 1'b0;
        repeat (5) @(posedge clk);
        #1; rst = 1'b1; mem_wait = 1'b1;
        @(posedge clk); #1;
        chk_reset("mid-instruction");
        @(posedge clk); #1;
        rst = 1'b0;
        mon_on = 1'b1;
        run(2'b00, 1'b0, 8'h00);   // R2 recovery after reset
        mon_on = 1'b0;
        summary();
    end
endmodule